// File: doc/BRIEF.md
# Paged Lookup-Table Address Translator

This block owns one memory base address register whose decode window is cut into exactly 64 equal pages. Each page is remapped through its own entry in a 64-entry lookup table. A run-time page-size code sets the page size. That code also sets the window size, which is always 64 pages, and the number of base-address bits that can be written.

An incoming upstream memory address is compared against the window. When it falls inside, the six address bits just above the page offset choose a table entry. The entry's enable bit decides whether the access is claimed. A claimed access leaves the block with its upper bits replaced by the entry's translated page base, and its page offset is passed through unchanged.

Software-side agents load the base register and the table through one indexed write port. The translated result is registered, so it appears on the cycle after the address is presented.

Top module: `plxl_xlat`

## Requirements
- R1: After reset, `out_hit` is 0, `out_addr` is 0, `base_rd` is 0, and every table entry is disabled.
- R2: In `base_rd`, only bits from `shift+6` upward hold written base bits. All lower base bits read 0. Bit 0 (space, 0 = memory) and bit 3 (prefetchable) always read 0.
- R3: `base_rd[2:1]` is the address-type field. A write with code 00 (32-bit decode) or 01 (64-bit decode) is stored. A write with code 10 or 11 leaves the stored type unchanged.
- R4: The page shift is `8 + pg_size`, clamped to at most 25. Page size therefore ranges from 256 B to 32 MB, and the window from 16 KB to 2 GB. A size change takes effect on the next lookup and on `base_rd` at once.
- R5: When `in_valid` is 1 and `in_addr` lies in the window of an enabled page, `out_hit` is 1 on the following cycle.
- R6: On a hit, `out_addr` is the entry's bits `[31:shift]` followed by `in_addr[shift-1:0]`.
- R7: The page index is `in_addr[shift+5:shift]`, so page 0 through page 63 each use their own entry.
- R8: A table entry with bit 0 = 0 is disabled. An in-window access to that page gives `out_hit` = 0 and `out_addr` = 0.
- R9: An address whose bits `[31:shift+6]` differ from the base gives `out_hit` = 0 and `out_addr` = 0.
- R10: A table write (`reg_sel` = 1, `reg_idx` = entry) is used by a lookup presented on the very next cycle.
- R11: When `in_valid` is 0, `out_hit` is 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = base register, 1 = table entry |
| reg_idx | input | 6 | Table entry index |
| reg_wdata | input | 32 | Write data |
| pg_size | input | 5 | Page-size code |
| in_valid | input | 1 | Address valid |
| in_addr | input | 32 | Upstream memory address |
| out_hit | output | 1 | Registered hit flag |
| out_addr | output | 32 | Registered translated address, 0 on a miss |
| base_rd | output | 32 | Base register as seen by a reader |

## Verification
A lookup has one register stage. The hit flag and the translated address for an address presented before edge N are both valid after edge N. The bench drives every input on a falling edge and samples on the falling edge that follows the next rising edge.

`base_rd` is combinational from its register and `pg_size`. It is checked on the falling edge right after a write edge, or right after a size change with no edge in between.

For R10, a table write is placed in the cycle directly before a lookup, so that the lookup meets the new entry with no spare cycle between them.

// File: rtl/plxl_pkg.sv
// Shared types for the paged translator.
// Assumes the address-type field is two bits wide and that only codes 00 and 01 are legal.
package plxl_pkg;
    typedef enum logic [1:0] {
        ADT_32  = 2'b00,
        ADT_64  = 2'b01,
        ADT_R2  = 2'b10,
        ADT_R3  = 2'b11
    } adt_e;

    // True for the address-type codes the register accepts.
    function automatic logic adt_legal(input logic [1:0] code);
        return (code == ADT_32) || (code == ADT_64);
    endfunction
endpackage

// File: rtl/plxl_size.sv
// Turns the page-size code into a page shift, a page-offset mask and a window mask.
// Assumes MIN_SHIFT + IDX_W <= ADDR_W - 1. Codes past the largest size clamp to it.
module plxl_size #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 6,
    parameter int MIN_SHIFT = 8,
    parameter int PSZ_W     = 5,
    parameter int SHW       = $clog2(ADDR_W)
) (
    input  logic [PSZ_W-1:0]  pg_size,
    output logic [SHW-1:0]    shift,
    output logic [ADDR_W-1:0] page_mask,
    output logic [ADDR_W-1:0] win_mask
);
    localparam int MAX_SHIFT = ADDR_W - 1 - IDX_W;

    logic [31:0] sh;

    // Clamp the requested shift and derive both masks from it.
    always_comb begin
        sh = 32'(MIN_SHIFT) + 32'(pg_size);
        if (sh > 32'(MAX_SHIFT)) sh = 32'(MAX_SHIFT);
        shift     = SHW'(sh);
        page_mask = (ADDR_W'(1) << sh) - ADDR_W'(1);
        win_mask  = ~((ADDR_W'(1) << (sh + 32'(IDX_W))) - ADDR_W'(1));
    end
endmodule

// File: rtl/plxl_base.sv
// Base address register of the window.
// Only bits inside the current window mask are stored or read back. Bits 0 and 3 read 0.
// Type codes that are not legal leave the stored type as it was.
module plxl_base
    import plxl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic [ADDR_W-1:0] win_mask,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] base_rd
);
    logic [ADDR_W-1:0] base_r;
    logic [1:0]        type_r;
    logic              unused_bits;

    assign unused_bits = ^{wdata[3], wdata[0]};

    // Store the writable base bits and any legal type code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_r <= '0;
            type_r <= ADT_32;
        end else if (wr) begin
            base_r <= wdata & win_mask;
            if (adt_legal(wdata[2:1])) type_r <= wdata[2:1];
        end
    end

    // Mask again on the way out, so that a larger page hides bits that are no longer writable.
    always_comb begin
        base_q  = base_r & win_mask;
        base_rd = base_q | {{(ADDR_W-3){1'b0}}, type_r, 1'b0};
    end
endmodule

// File: rtl/plxl_lut.sv
// Page lookup table: one entry per page, holding the translated page bits and an enable bit.
// Writes land at the clock edge, and the read port is combinational on the current index.
module plxl_lut #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 6,
    parameter int MIN_SHIFT = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [ADDR_W-1:0]     wdata,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [ADDR_W-1:0]     rd_base,
    output logic                  rd_en
);
    localparam int NPAGES = 1 << IDX_W;
    localparam int UPW    = ADDR_W - MIN_SHIFT;

    logic [UPW-1:0]    up_q [NPAGES];
    logic [NPAGES-1:0] en_q;
    logic              unused_bits;

    assign unused_bits = ^wdata[MIN_SHIFT-1:1];

    // Hold each entry's upper bits and enable. Reset disables every page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int i = 0; i < NPAGES; i++) up_q[i] <= '0;
        end else if (wr) begin
            en_q[wr_idx]  <= wdata[0];
            up_q[wr_idx]  <= wdata[ADDR_W-1:MIN_SHIFT];
        end
    end

    // Read the entry selected by the lookup.
    always_comb begin
        rd_base = {up_q[rd_idx], {MIN_SHIFT{1'b0}}};
        rd_en   = en_q[rd_idx];
    end
endmodule

// File: rtl/plxl_xlat.sv
// Paged translator top.
// Matches the address against the base window, picks a page from the bits above the offset,
// gates the result with the page enable, and registers the hit and the translated address.
module plxl_xlat #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 6,
    parameter int MIN_SHIFT = 8,
    parameter int PSZ_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_sel,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic [PSZ_W-1:0]  pg_size,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_hit,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] base_rd
);
    localparam int SHW = $clog2(ADDR_W);

    logic [SHW-1:0]    shift;
    logic [ADDR_W-1:0] page_mask, win_mask, base_q, ent_base;
    logic [IDX_W-1:0]  idx;
    logic              ent_en, in_win, hit_n;
    logic [ADDR_W-1:0] xl_addr;

    plxl_size #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MIN_SHIFT(MIN_SHIFT), .PSZ_W(PSZ_W), .SHW(SHW)) u_size (
        .pg_size(pg_size), .shift(shift), .page_mask(page_mask), .win_mask(win_mask));

    plxl_base #(.ADDR_W(ADDR_W)) u_base (
        .clk(clk), .rst_n(rst_n), .wr(reg_we && !reg_sel), .wdata(reg_wdata),
        .win_mask(win_mask), .base_q(base_q), .base_rd(base_rd));

    plxl_lut #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MIN_SHIFT(MIN_SHIFT)) u_lut (
        .clk(clk), .rst_n(rst_n), .wr(reg_we && reg_sel), .wr_idx(reg_idx), .wdata(reg_wdata),
        .rd_idx(idx), .rd_base(ent_base), .rd_en(ent_en));

    // Window match, page index and translated address for the current input.
    always_comb begin
        idx     = IDX_W'(in_addr >> shift);
        in_win  = (in_addr & win_mask) == base_q;
        hit_n   = in_valid && in_win && ent_en;
        xl_addr = (ent_base & ~page_mask) | (in_addr & page_mask);
    end

    // Lookup result register. A miss drives the address to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_hit  <= 1'b0;
            out_addr <= '0;
        end else begin
            out_hit  <= hit_n;
            out_addr <= hit_n ? xl_addr : '0;
        end
    end
endmodule

// File: rtl/plxl_xlat_chk.sv
// Property checker for plxl_xlat, attached to every instance by the bind below.
module plxl_xlat_chk #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 6,
    parameter int MIN_SHIFT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              out_hit,
    input logic [ADDR_W-1:0] out_addr,
    input logic [ADDR_W-1:0] base_rd
);
    a_r11_idle_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> !out_hit);
    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_hit |-> out_addr == '0);
    a_r6_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> out_addr[MIN_SHIFT-1:0] == $past(in_addr[MIN_SHIFT-1:0]));
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        !base_rd[0] && !base_rd[3] && base_rd[MIN_SHIFT+IDX_W-1:4] == '0);
    a_r3_type_legal: assert property (@(posedge clk) disable iff (!rst_n)
        !base_rd[2]);
endmodule

bind plxl_xlat plxl_xlat_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .MIN_SHIFT(MIN_SHIFT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .out_hit(out_hit), .out_addr(out_addr), .base_rd(base_rd));

// File: tb/sim_plxl_xlat.sv
module sim_plxl_xlat;
    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0, reg_sel = 0, in_valid = 0;
    logic [5:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0, in_addr = '0;
    logic [4:0]  pg_size = '0;
    logic        out_hit;
    logic [31:0] out_addr, base_rd;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    plxl_xlat u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .pg_size(pg_size), .in_valid(in_valid), .in_addr(in_addr),
        .out_hit(out_hit), .out_addr(out_addr), .base_rd(base_rd));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_base(input logic [31:0] d);
        reg_we = 1; reg_sel = 0; reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic wr_ent(input int i, input logic [31:0] d);
        reg_we = 1; reg_sel = 1; reg_idx = 6'(i); reg_wdata = d;
        @(negedge clk); reg_we = 0;
    endtask

    task automatic look(input string req, input logic [31:0] a, input logic h, input logic [31:0] x);
        in_valid = 1; in_addr = a;
        @(negedge clk); in_valid = 0;
        chk({req, " hit"}, 32'(out_hit), 32'(h));
        chk({req, " addr"}, out_addr, x);
    endtask

    task automatic t_reset;
        chk("R1 hit", 32'(out_hit), 0);
        chk("R1 addr", out_addr, 0);
        chk("R1 base", base_rd, 0);
        look("R1 entries off", 32'h0000_0010, 0, 0);
    endtask

    task automatic t_base_bits;
        pg_size = 0;
        wr_base(32'hFFFF_FFFF);
        chk("R2 writable mask", base_rd, 32'hFFFF_C000);
        wr_base(32'h0000_0002);
        chk("R3 type 01", base_rd, 32'h0000_0002);
        wr_base(32'h1234_0004);
        chk("R3 type 10 ignored", base_rd, 32'h1234_0002);
    endtask

    task automatic t_translate;
        pg_size = 0;
        wr_base(32'h4000_0000);
        wr_ent(5, 32'hABCD_1201);
        wr_ent(6, 32'hABCD_0000);
        look("R5 R6 R7 page5", 32'h4000_053C, 1, 32'hABCD_123C);
        look("R8 disabled page", 32'h4000_063C, 0, 0);
        look("R9 outside", 32'h4000_4000, 0, 0);
        in_addr = 32'h4000_053C;
        @(negedge clk);
        chk("R11 idle", 32'(out_hit), 0);
    endtask

    task automatic t_size4;
        pg_size = 4;
        #1;
        chk("R4 base after size", base_rd, 32'h4000_0000);
        wr_base(32'h4003_C000);
        chk("R2 R4 mask 256K", base_rd, 32'h4000_0000);
        wr_ent(63, 32'h7777_7001);
        look("R7 page63", 32'h4003_FABC, 1, 32'h7777_7ABC);
    endtask

    task automatic t_clamp;
        pg_size = 31;
        wr_base(32'hFFFF_FFFF);
        chk("R4 clamp base", base_rd, 32'h8000_0000);
        wr_ent(3, 32'h0600_0001);
        look("R4 R6 2G page3", 32'h8612_3456, 1, 32'h0612_3456);
        look("R9 2G outside", 32'h0612_3456, 0, 0);
    endtask

    task automatic t_next;
        pg_size = 0;
        wr_base(32'h4000_0000);
        look("R10 before", 32'h4000_0911, 0, 0);
        wr_ent(9, 32'h1111_2201);
        look("R10 after", 32'h4000_0911, 1, 32'h1111_2211);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_base_bits;
        t_translate;
        t_size4;
        t_clamp;
        t_next;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule